// File: doc/BRIEF.md
# Video Encoder Configuration Register Port (two-wire serial, write-only)

This block lets a host processor set four configuration registers of a video encoder over a two-wire serial bus. It acts as a bus target with the fixed 7-bit address 1000100 (0x44). The host sends a start condition, an address byte, a subaddress byte that selects the first register, and then as many data bytes as it needs, followed by a stop. Each accepted byte is acknowledged by pulling SDA low during the ninth clock. Successive data bytes go to successive registers. The block never answers a read. It refuses acknowledge for a foreign address and for a subaddress it does not have.

The bus lines are oversampled by the system clock. SCL and SDA pass through a two-flop synchroniser and an edge detector. A start or stop is recognised as an SDA edge while SCL is high. Most fields act as soon as their byte has been received. Two fields are held in a shadow copy and move to their working copy only on a vertical-blanking strobe, so that a change does not tear a visible field: the black-level setup bit and the 2-bit overlay level. The last register holds a 4-bit luminance level code. Codes above 10 are kept as written but act as 10.

Top module: `vid_cfg_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits (sent MSB first) equal 0x44 and whose last bit (read/write flag) is 0 is acknowledged. Acknowledge means that sda_oe_o is high while SCL is high in the ninth clock of the byte.
- R2: An address byte with any other 7-bit address gets no acknowledge. Every later byte up to the next start or stop also gets none, and no register changes.
- R3: The address 0x44 with the read/write flag at 1 (read) gets no acknowledge. The rest of the transfer is ignored.
- R4: A subaddress byte of 0 to 3 is acknowledged. A subaddress of 4 or more is refused, and every data byte that follows it in the same transfer is also refused and discarded.
- R5: Data bytes are written to the selected subaddress and then to each next one. A data byte that would go beyond subaddress 3 is refused and discarded.
- R6: Register 0 (mode_o) and all other fields not named in R7 show a written value as soon as the byte has been received, with no blanking strobe.
- R7: Bit 1 of register 1 (black-level setup) and bits 1:0 of register 2 (overlay level) appear on ctrl_o[1] and ovl_o[1:0] only after a one-cycle pulse on vblank_i. They keep their old value until then.
- R8: Register 3 keeps only the four LSBs of a written byte, shown on luma_code_o. luma_level_o equals that code when it is 10 or less, and 10 otherwise.
- R9: After reset every register and working copy is zero and sda_oe_o is low.
- R10: A start condition at any point, including in the middle of a byte, begins a new address phase. A stop releases SDA and returns the block to idle.
- R11: sda_oe_o changes only while SCL is low. It is released after the SCL falling edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| vblank_i | input | 1 | One-cycle vertical-blanking strobe |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| mode_o | output | 8 | Register 0 |
| ctrl_o | output | 8 | Register 1; bit 1 is the deferred setup bit |
| ovl_o | output | 8 | Register 2; bits 1:0 are the deferred overlay level |
| luma_code_o | output | 4 | Register 3 as stored |
| luma_level_o | output | 4 | Effective luminance level code, at most 10 |

## Verification
The hardest situation to reach from the ports is a start condition that arrives part-way through a byte, while the bit counter and the shift register hold partial state. The bench drives that case with a raw bit task that clocks four bits and then issues a start. It then runs a full transfer and expects it to be acknowledged and written correctly. The refusal paths are swept over every 7-bit address and over a range of subaddresses with multi-byte bursts. A reference model in the bench predicts each acknowledge bit and each register value, including the clamped luminance level and the shadowed fields before and after the blanking strobe.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 4;
  localparam int LUMA_W    = 4;
  localparam int LUMA_MAX  = 10;
  localparam int SETUP_BIT = 1;
  localparam int OVL_W     = 2;
  localparam logic [6:0] SLV_ADDR = 7'h44;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_IGN} bus_st_e;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh_q, sda_sh_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[SYNC_STAGES-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q  <= scl_sh_q[SYNC_STAGES-1];
      sda_d_q  <= sda_sh_q[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sh_q[SYNC_STAGES-1];
  assign sda_o      = sda_sh_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  // SDA edges only count while SCL is high on both samples
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import vcfg_pkg::*;
#(
  parameter logic [6:0] ADDR  = SLV_ADDR,
  parameter int         NREGS = NUM_REGS,
  localparam int        AW    = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             ack_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [REG_W-1:0] wr_data_o
);
  bus_st_e          st_q;
  byte_kind_e       kind_q;
  logic [3:0]       bit_cnt_q;
  logic [REG_W-1:0] sh_q;
  logic             ack_q;
  logic [AW-1:0]    ptr_q;
  logic             ptr_ok_q;
  logic             wr_en_q;
  logic [AW-1:0]    wr_addr_q;
  logic [REG_W-1:0] wr_data_q;
  logic             byte_ok;

  always_comb begin
    case (kind_q)
      K_ADDR:  byte_ok = (sh_q == {ADDR, 1'b0});
      K_SUB:   byte_ok = (sh_q < REG_W'(NREGS));
      default: byte_ok = ptr_ok_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      ack_q     <= 1'b0;
      ptr_q     <= '0;
      ptr_ok_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
        ptr_ok_q  <= 1'b0;
      end else if (stop_i) begin
        st_q  <= ST_IDLE;
        ack_q <= 1'b0;
      end else begin
        case (st_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q < 4'd8) begin
              sh_q      <= {sh_q[REG_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              st_q      <= ST_ACK;
              ack_q     <= byte_ok;
              if (kind_q == K_SUB) begin
                ptr_q    <= sh_q[AW-1:0];
                ptr_ok_q <= byte_ok;
              end else if (kind_q == K_DATA && byte_ok) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= sh_q;
                if (ptr_q == AW'(NREGS - 1)) ptr_ok_q <= 1'b0;
                else                         ptr_q    <= ptr_q + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              ack_q <= 1'b0;
              st_q  <= (kind_q == K_ADDR && !ack_q) ? ST_IGN : ST_RX;
              if (kind_q == K_ADDR) kind_q <= K_SUB;
              else                  kind_q <= K_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_o     = ack_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  assert_ack_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> !scl_i);
  assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !ack_q);
  assert_start_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (bit_cnt_q == 4'd0 && kind_q == K_ADDR && !ack_q));
  assert_write_acked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> ack_q);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import vcfg_pkg::*;
#(
  parameter int  NREGS  = NUM_REGS,
  parameter int  LAST_W = LUMA_W,
  parameter int  LVL_MAX = LUMA_MAX,
  localparam int AW     = $clog2(NREGS),
  localparam logic [REG_W-1:0] LAST_MASK = REG_W'((1 << LAST_W) - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              vblank_i,
  output logic [REG_W-1:0]  mode_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  ovl_o,
  output logic [LAST_W-1:0] luma_code_o,
  output logic [LAST_W-1:0] luma_level_o
);
  logic [REG_W-1:0] reg_q [NREGS];
  logic             setup_act_q;
  logic [OVL_W-1:0] ovl_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) reg_q[i] <= '0;
      setup_act_q <= 1'b0;
      ovl_act_q   <= '0;
    end else begin
      if (wr_en_i)
        reg_q[wr_addr_i] <= (wr_addr_i == AW'(NREGS - 1)) ? (wr_data_i & LAST_MASK) : wr_data_i;
      // shadow to working copy only in blanking
      if (vblank_i) begin
        setup_act_q <= reg_q[1][SETUP_BIT];
        ovl_act_q   <= reg_q[2][OVL_W-1:0];
      end
    end
  end

  assign mode_o = reg_q[0];

  always_comb begin
    ctrl_o            = reg_q[1];
    ctrl_o[SETUP_BIT] = setup_act_q;
    ovl_o             = reg_q[2];
    ovl_o[OVL_W-1:0]  = ovl_act_q;
  end

  assign luma_code_o  = reg_q[NREGS-1][LAST_W-1:0];
  assign luma_level_o = (luma_code_o > LAST_W'(LVL_MAX)) ? LAST_W'(LVL_MAX) : luma_code_o;

  assert_setup_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(ctrl_o[SETUP_BIT]));
  assert_ovl_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(ovl_o[OVL_W-1:0]));
  assert_luma_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    luma_level_o <= LAST_W'(LVL_MAX));
endmodule

// File: rtl/vid_cfg_i2c_slave.sv
module vid_cfg_i2c_slave
  import vcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              vblank_i,
  output logic              sda_oe_o,
  output logic [REG_W-1:0]  mode_o,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  ovl_o,
  output logic [LUMA_W-1:0] luma_code_o,
  output logic [LUMA_W-1:0] luma_level_o
);
  localparam int AW = $clog2(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0]    wr_addr;
  logic [REG_W-1:0] wr_data;

  i2c_line_sync #(.SYNC_STAGES(2)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_wr_fsm #(.ADDR(SLV_ADDR), .NREGS(NUM_REGS)) i_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .ack_o(sda_oe_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  cfg_regs #(.NREGS(NUM_REGS), .LAST_W(LUMA_W), .LVL_MAX(LUMA_MAX)) i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .vblank_i, .mode_o, .ctrl_o, .ovl_o, .luma_code_o, .luma_level_o
  );
endmodule

// File: tb/test_vid_cfg_i2c_slave.sv
module test_vid_cfg_i2c_slave;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, vblank = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [7:0] mode, ctrl, ovl;
  logic [3:0] lcode, llvl;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  vid_cfg_i2c_slave i_vid_cfg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .vblank_i(vblank),
    .sda_oe_o(sda_oe), .mode_o(mode), .ctrl_o(ctrl), .ovl_o(ovl),
    .luma_code_o(lcode), .luma_level_o(llvl)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m [4];
  logic act_setup = 1'b0;
  logic [1:0] act_ovl = 2'b0;
  logic [7:0] tx [8];
  int tx_n;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = ~sda_bus;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  // reference model for acknowledge and register contents
  task automatic run_xfer(input string tag, input bit with_stop);
    bit addr_ok, chain_ok, exp;
    int ptr;
    logic got;
    addr_ok = 1'b0; chain_ok = 1'b0; ptr = 0;
    bus_start();
    for (int i = 0; i < tx_n; i++) begin
      if (i == 0) begin
        addr_ok = (tx[0] == 8'h88);
        exp = addr_ok;
      end else if (i == 1) begin
        chain_ok = addr_ok && (tx[1] < 8'd4);
        ptr = int'(tx[1]);
        exp = chain_ok;
      end else begin
        exp = chain_ok && (ptr < 4);
        if (exp) begin
          m[ptr] = (ptr == 3) ? (tx[i] & 8'h0F) : tx[i];
          ptr++;
        end
      end
      send_byte(tx[i], got);
      check($sformatf("%s ack byte %0d", tag, i), {31'd0, got}, {31'd0, exp});
    end
    if (with_stop) bus_stop();
  endtask

  task automatic check_regs(input string tag);
    logic [3:0] lv;
    wq(4);
    lv = (m[3][3:0] > 4'd10) ? 4'd10 : m[3][3:0];
    check({tag, " R6 mode"}, {24'd0, mode}, {24'd0, m[0]});
    check({tag, " R7 ctrl"}, {24'd0, ctrl}, {24'd0, m[1][7:2], act_setup, m[1][0]});
    check({tag, " R7 ovl"}, {24'd0, ovl}, {24'd0, m[2][7:2], act_ovl});
    check({tag, " R8 code"}, {28'd0, lcode}, {28'd0, m[3][3:0]});
    check({tag, " R8 level"}, {28'd0, llvl}, {28'd0, lv});
    check({tag, " R11 released"}, {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic pulse_vblank();
    vblank = 1'b1; wq(1); vblank = 1'b0;
    act_setup = m[1][1];
    act_ovl   = m[2][1:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    wq(3);
    // R9 reset state
    check("R9 mode", {24'd0, mode}, 32'd0);
    check("R9 ctrl", {24'd0, ctrl}, 32'd0);
    check("R9 ovl", {24'd0, ovl}, 32'd0);
    check("R9 luma", {24'd0, lcode, llvl}, 32'd0);
    check("R9 sda_oe", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    wq(4);

    // R1 R2: every 7-bit address, write flag 0
    for (int a = 0; a < 128; a++) begin
      tx[0] = {a[6:0], 1'b0}; tx[1] = 8'h00; tx[2] = 8'(a + 1); tx_n = 3;
      run_xfer(a == 'h44 ? "R1 addr" : "R2 addr", 1'b1);
    end
    check_regs("R2 after sweep");

    // R3 read flag refused
    tx[0] = 8'h89; tx[1] = 8'h00; tx[2] = 8'h5A; tx_n = 3;
    run_xfer("R3 read", 1'b1);
    check_regs("R3 unchanged");

    // R4 R5 subaddress sweep with bursts of three
    for (int s = 0; s < 8; s++) begin
      tx[0] = 8'h88; tx[1] = 8'(s); tx[2] = 8'(8'h30 + s); tx[3] = 8'(8'h40 + s);
      tx[4] = 8'(8'hC0 + s); tx_n = 5;
      run_xfer(s < 4 ? "R5 sub" : "R4 bad sub", 1'b1);
      check_regs("R4 R5 sub sweep");
    end
    tx[0] = 8'h88; tx[1] = 8'hFF; tx[2] = 8'h11; tx_n = 3;
    run_xfer("R4 sub FF", 1'b1);
    check_regs("R4 sub FF");

    // R5 full burst and overrun
    tx[0] = 8'h88; tx[1] = 8'h00; tx[2] = 8'hA1; tx[3] = 8'hFC; tx[4] = 8'hFF;
    tx[5] = 8'h97; tx[6] = 8'h55; tx_n = 7;
    run_xfer("R5 burst", 1'b1);
    check_regs("R5 burst");

    // R7 deferred fields
    pulse_vblank();
    check_regs("R7 after strobe");
    tx[0] = 8'h88; tx[1] = 8'h01; tx[2] = 8'h00; tx[3] = 8'h00; tx_n = 4;
    run_xfer("R7 clear", 1'b1);
    check_regs("R7 held");
    pulse_vblank();
    check_regs("R7 cleared");
    tx[0] = 8'h88; tx[1] = 8'h01; tx[2] = 8'h02; tx[3] = 8'h01; tx_n = 4;
    run_xfer("R7 set", 1'b1);
    check_regs("R7 held2");
    pulse_vblank();
    check_regs("R7 applied");

    // R8 luminance codes, all sixteen
    for (int c = 0; c < 16; c++) begin
      tx[0] = 8'h88; tx[1] = 8'h03; tx[2] = 8'(8'hA0 | c); tx_n = 3;
      run_xfer("R8 luma", 1'b1);
      check_regs("R8 luma");
    end

    // R10 repeated start without stop
    tx[0] = 8'h88; tx[1] = 8'h00; tx[2] = 8'h3C; tx_n = 3;
    run_xfer("R10 first", 1'b0);
    tx[0] = 8'h88; tx[1] = 8'h02; tx[2] = 8'hE6; tx_n = 3;
    run_xfer("R10 repeated", 1'b1);
    check_regs("R10 repeated");

    // R10 start in the middle of a byte
    bus_start();
    send_bits(8'h88, 8);
    begin
      logic a0;
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); a0 = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
      check("R10 partial addr ack", {31'd0, a0}, 32'd1);
    end
    send_bits(8'h01, 4);
    tx[0] = 8'h88; tx[1] = 8'h00; tx[2] = 8'h77; tx_n = 3;
    run_xfer("R10 mid-byte", 1'b1);
    check_regs("R10 mid-byte");

    // R10 stop after address returns to idle, SDA released
    bus_start();
    begin
      logic a1;
      send_byte(8'h88, a1);
      check("R10 addr before stop", {31'd0, a1}, 32'd1);
    end
    bus_stop();
    check_regs("R10 stop idle");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule